// File: doc/BRIEF.md
# Repeating Status Word Streamer

This block is the device-side responder for a status query on a four-wire serial interface. The interface idles with the clock low. Data from the host is taken on rising SCK edges, and the device changes its output on falling SCK edges. When the host selects the device and clocks in the 8-bit query opcode, the block begins to drive an 8-bit status word on SO, most significant bit first. The word repeats without a break for as long as the select stays low and the clock keeps running.

The top bit of the word is the ready flag, which is the inverse of the live `dev_busy` input. While that bit is on SO, the output follows the busy input from cycle to cycle. A host can therefore stop SCK during the top bit and poll until the device is ready. The lower bits are captured from `dev_info` and a fixed reserved pattern at the start of each pass, so every pass carries fresh values.

The serial pins are brought into the `clk` domain through synchronizer chains, and edges are detected there. SO and its enable are registered. The device's pad logic drives SO only while `so_oe` is high.

Top module: `status_stream`

## Requirements
- R1: After reset and whenever CS (`cs_n`) is high, `so_oe` is 0 and `so` is 0. A select released in the middle of a word turns the output off.
- R2: The opcode is taken MSB first from `si`, one bit on each of the first 8 rising SCK edges after CS falls. Only the value 0x57 starts the status stream.
- R3: Any other 8-bit opcode leaves `so_oe` at 0 for the rest of that selection, however many further SCK edges arrive.
- R4: The falling SCK edge that follows the 8th opcode rising edge drives bit 7 and raises `so_oe`. Each later falling edge steps to the next lower bit.
- R5: Word layout: bit 7 = NOT `dev_busy` (1 means ready), bits 6..3 = `dev_info[3:0]` with `dev_info[3]` in bit 6, bits 2..0 = the reserved fill parameter (default 000).
- R6: The falling edge after bit 0 restarts the word at bit 7. This repeats with no limit on the number of passes.
- R7: Bits 6..3 are captured from `dev_info` at the falling edge that starts each pass. A change during a pass appears only in the next pass.
- R8: While bit 7 is on SO, `so` follows NOT `dev_busy` within 2 `clk` cycles, even when SCK is held still.
- R9: SCK edges while CS is high are ignored. Each new selection starts opcode reception again from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCK is oversampled by it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low (asynchronous) |
| sck | input | 1 | Serial clock (asynchronous) |
| si | input | 1 | Serial data from host |
| dev_busy | input | 1 | Live busy flag, `clk` domain |
| dev_info | input | 4 | Device information bits for status bits 6..3 |
| so | output | 1 | Serial status data |
| so_oe | output | 1 | Drive enable for SO; 0 means high impedance |

## Verification
On every cycle, the assertions check three things: the output enable drops after deselection, the bit counter moves only on a falling SCK edge (down by one, or from 0 back to 7), and the top-bit output tracks the inverse of the busy flag one cycle later. Streaming is also checked to start only from a matched opcode. The bench scenarios cover the rest: the word contents for every value of the information field with both busy levels, every one of the 256 opcodes, a change of the information field in the middle of a pass, polling with SCK stopped, and selections aborted during the opcode and during the word.

// File: rtl/status_stream_pkg.sv
package status_stream_pkg;
  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_ARMED  = 2'd1,
    PH_REJECT = 2'd2
  } cmd_phase_e;
endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ss_edge.sv
module ss_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/ss_opdec.sv
module ss_opdec
  import status_stream_pkg::*;
#(
  parameter int              OP_W   = 8,
  parameter logic [OP_W-1:0] OPCODE = 8'h57
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_idle,
  input  logic rise,
  input  logic si,
  output logic armed
);
  localparam int CNT_W = $clog2(OP_W + 1);

  logic [OP_W-1:0]  sh;
  logic [OP_W-1:0]  sh_nxt;
  logic [CNT_W-1:0] cnt;
  cmd_phase_e       ph;

  assign sh_nxt = {sh[OP_W-2:0], si};

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      sh  <= '0;
      cnt <= '0;
      ph  <= PH_CMD;
    end else if (rise && ph == PH_CMD) begin
      sh <= sh_nxt;
      if (cnt == CNT_W'(OP_W - 1)) begin
        cnt <= '0;
        ph  <= (sh_nxt == OPCODE) ? PH_ARMED : PH_REJECT;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign armed = (ph == PH_ARMED);
endmodule

// File: rtl/ss_shifter.sv
module ss_shifter #(
  parameter int WORD_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              fall,
  input  logic              armed,
  input  logic              ready,
  input  logic [WORD_W-2:0] low_live,
  output logic              streaming,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              so_q,
  output logic              oe_q
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);

  logic [WORD_W-2:0] snap;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      streaming <= 1'b0;
      bit_idx   <= TOP_IDX;
      snap      <= '0;
    end else if (fall) begin
      if (!streaming) begin
        if (armed) begin
          streaming <= 1'b1;
          bit_idx   <= TOP_IDX;
          snap      <= low_live;
        end
      end else if (bit_idx == '0) begin
        bit_idx <= TOP_IDX;
        snap    <= low_live;
      end else begin
        bit_idx <= bit_idx - 1'b1;
      end
    end
  end

  // The top bit is taken live, so it tracks the busy flag while SCK is held.
  assign word = {ready, snap};

  always_ff @(posedge clk) begin
    if (rst) begin
      so_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      oe_q <= streaming & ~cs_idle;
      so_q <= streaming & ~cs_idle & word[bit_idx];
    end
  end
endmodule

// File: rtl/status_stream.sv
module status_stream #(
  parameter int              OP_W        = 8,
  parameter logic [OP_W-1:0] OPCODE      = 8'h57,
  parameter int              WORD_W      = 8,
  parameter int              INFO_W      = 4,
  parameter int              SYNC_STAGES = 2,
  parameter int              RSVD_VAL    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              dev_busy,
  input  logic [INFO_W-1:0] dev_info,
  output logic              so,
  output logic              so_oe
);
  localparam int RSVD_W = WORD_W - 1 - INFO_W;
  localparam int IDX_W  = $clog2(WORD_W);

  logic [2:0]        pins_s;
  logic              cs_idle;
  logic              sck_s;
  logic              si_s;
  logic              sck_rise;
  logic              sck_fall;
  logic              armed;
  logic              streaming;
  logic [IDX_W-1:0]  bit_idx;
  logic [WORD_W-2:0] low_live;

  ss_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sck, si}),
    .q   (pins_s)
  );

  assign cs_idle = pins_s[2];
  assign sck_s   = pins_s[1];
  assign si_s    = pins_s[0];

  ss_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (sck_s),
    .rise (sck_rise),
    .fall (sck_fall)
  );

  ss_opdec #(.OP_W(OP_W), .OPCODE(OPCODE)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .cs_idle (cs_idle),
    .rise    (sck_rise),
    .si      (si_s),
    .armed   (armed)
  );

  assign low_live = {dev_info, RSVD_W'(RSVD_VAL)};

  ss_shifter #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .cs_idle   (cs_idle),
    .fall      (sck_fall),
    .armed     (armed),
    .ready     (~dev_busy),
    .low_live  (low_live),
    .streaming (streaming),
    .bit_idx   (bit_idx),
    .so_q      (so),
    .oe_q      (so_oe)
  );
endmodule

// File: rtl/status_stream_chk.sv
module status_stream_chk #(
  parameter int IDX_W  = 3,
  parameter int WORD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_idle,
  input logic             sck_fall,
  input logic             armed,
  input logic             streaming,
  input logic [IDX_W-1:0] bit_idx,
  input logic             dev_busy,
  input logic             so,
  input logic             so_oe
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);

  assert_oe_off_deselected_R1: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !so_oe);

  assert_stream_needs_match_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(streaming) |-> $past(armed));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (sck_fall && streaming && !cs_idle && bit_idx != '0) |=> bit_idx == IDX_W'($past(bit_idx) - 1'b1));

  assert_wrap_top_R6: assert property (@(posedge clk) disable iff (rst)
    (sck_fall && streaming && !cs_idle && bit_idx == '0) |=> bit_idx == TOP_IDX);

  assert_idx_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!sck_fall && !cs_idle) |=> $stable(bit_idx));

  assert_live_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (streaming && !cs_idle && bit_idx == TOP_IDX) |=> so == !$past(dev_busy));
endmodule

bind status_stream status_stream_chk #(.IDX_W($clog2(WORD_W)), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_idle   (cs_idle),
  .sck_fall  (sck_fall),
  .armed     (armed),
  .streaming (streaming),
  .bit_idx   (bit_idx),
  .dev_busy  (dev_busy),
  .so        (so),
  .so_oe     (so_oe)
);

// File: tb/status_stream_tb.sv
module status_stream_tb;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       si = 1'b0;
  logic       dev_busy = 1'b0;
  logic [3:0] dev_info = 4'h0;
  logic       so;
  logic       so_oe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  status_stream u_dut (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .si       (si),
    .dev_busy (dev_busy),
    .dev_info (dev_info),
    .so       (so),
    .so_oe    (so_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse();
    sck = 1'b1; wait_clk(H);
    sck = 1'b0; wait_clk(H);
  endtask

  task automatic select();
    cs_n = 1'b0; wait_clk(H);
  endtask

  task automatic deselect();
    cs_n = 1'b1; sck = 1'b0; wait_clk(H);
  endtask

  task automatic send_op(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) begin
      si = op[i];
      pulse();
    end
  endtask

  // Samples one 8-bit pass; optionally changes dev_info after the 4th bit.
  task automatic read_word(output logic [7:0] v, input logic chg, input logic [3:0] nv);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      v = {v[6:0], so};
      if (chg && i == 3) dev_info = nv;
      pulse();
    end
  endtask

  function automatic logic [7:0] expect_word(input logic b, input logic [3:0] inf);
    return {~b, inf, 3'b000};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    // R1: reset state
    chk(so_oe == 1'b0 && so == 1'b0, "R1 reset", {6'b0, so_oe, so}, 8'h00);

    // R4 R5 R6: every info value with both busy levels, two passes each
    for (int b = 0; b < 2; b++) begin
      for (int inf = 0; inf < 16; inf++) begin
        dev_busy = b[0];
        dev_info = inf[3:0];
        select();
        send_op(8'h57);
        chk(so_oe == 1'b1, "R4 enable", {7'b0, so_oe}, 8'h01);
        read_word(w, 1'b0, 4'h0);
        chk(w == expect_word(b[0], inf[3:0]), "R5 word", w, expect_word(b[0], inf[3:0]));
        read_word(w, 1'b0, 4'h0);
        chk(w == expect_word(b[0], inf[3:0]), "R6 repeat", w, expect_word(b[0], inf[3:0]));
        deselect();
        chk(so_oe == 1'b0, "R1 deselect", {7'b0, so_oe}, 8'h00);
      end
    end

    // R2 R3: every opcode; only 0x57 enables the output
    dev_busy = 1'b0;
    for (int op = 0; op < 256; op++) begin
      logic want;
      logic seen;
      want = (op == 8'h57);
      seen = 1'b0;
      select();
      send_op(op[7:0]);
      for (int k = 0; k < 4; k++) begin
        seen = seen | so_oe;
        pulse();
      end
      seen = seen | so_oe;
      chk(seen == want, want ? "R2 match" : "R3 reject", {7'b0, seen}, {7'b0, want});
      deselect();
    end

    // R7: a mid-pass change appears only in the following pass
    dev_info = 4'h5;
    select();
    send_op(8'h57);
    read_word(w, 1'b1, 4'hA);
    chk(w == expect_word(1'b0, 4'h5), "R7 old pass", w, expect_word(1'b0, 4'h5));
    read_word(w, 1'b1, 4'h3);
    chk(w == expect_word(1'b0, 4'hA), "R7 next pass", w, expect_word(1'b0, 4'hA));
    read_word(w, 1'b0, 4'h0);
    chk(w == expect_word(1'b0, 4'h3), "R7 third pass", w, expect_word(1'b0, 4'h3));

    // R8: SCK held during bit 7, SO follows live busy
    for (int t = 0; t < 6; t++) begin
      dev_busy = t[0];
      wait_clk(3);
      chk(so == ~t[0], "R8 live ready", {7'b0, so}, {7'b0, ~t[0]});
    end
    dev_busy = 1'b0;
    wait_clk(3);
    // R1: abort mid-word
    pulse(); pulse(); pulse();
    deselect();
    chk(so_oe == 1'b0 && so == 1'b0, "R1 abort", {6'b0, so_oe, so}, 8'h00);

    // R9: partial opcode, deselect, SCK noise while deselected, fresh query
    select();
    si = 1'b1; pulse(); pulse(); pulse(); pulse();
    cs_n = 1'b1; wait_clk(H);
    for (int k = 0; k < 5; k++) begin
      si = k[0];
      pulse();
    end
    dev_info = 4'hC;
    select();
    send_op(8'h57);
    chk(so_oe == 1'b1, "R9 restart enable", {7'b0, so_oe}, 8'h01);
    read_word(w, 1'b0, 4'h0);
    chk(w == expect_word(1'b0, 4'hC), "R9 restart word", w, expect_word(1'b0, 4'hC));
    deselect();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule